// File: doc/BRIEF.md
# Timer Event Capture Unit

This block watches one chosen line out of a bank of general-purpose inputs, arranged as four ports of eight lines each. When the chosen line goes from low to high, the unit copies a free-running 32-bit timer value into a capture register and raises a valid flag. Once the flag is up the capture register is frozen: later events are ignored until software clears the flag. The timer is supplied from outside; the block only samples it.

Software selects the watched line through a small byte-wide register interface. A control register holds a port number and a line number. Some combinations are inhibit codes that turn capture off entirely. A status register carries the valid flag, and four byte registers return the captured stamp. Each input line passes through a two-flop synchroniser and a third flop that remembers its previous level. Edges are found on every line before the selection is applied, so changing the selection can never create an event by itself.

Top module: `evt_capture`

## Requirements
- R1: After reset the control register, the status register and all four capture bytes read 0, and so does the unused address 2.
- R2: Address 0 is the control register. Bits [5:3] hold the port select and bits [2:0] hold the line select. A write stores bits [5:0], a read returns them, and read bits [7:6] are 0.
- R3: A low-to-high change on the selected line (input index port*8+line) is followed by capture on the third rising clock edge after the change. On that edge the timer value present in the preceding cycle is stored, and the valid flag goes to 1.
- R4: A port select of 4, 5, 6 or 7 inhibits all capture.
- R5: A line select of 0 inhibits all capture, whatever the port.
- R6: While the valid flag is 1, further rising edges on the selected line leave both the captured value and the flag unchanged.
- R7: Address 1 is the status register, with the valid flag in bit 0. Writing 1 to bit 0 clears the flag; writing 0 to bit 0 leaves it unchanged.
- R8: If a flag-clear write lands on the same clock edge as a capture, the clear wins. The flag ends at 0, the captured value keeps its old contents, and that edge is lost.
- R9: Addresses 4, 5, 6 and 7 return captured bits [7:0], [15:8], [23:16] and [31:24] respectively.
- R10: Falling edges, rising edges on unselected lines, and moving the selection onto a line that is already high cause no capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 32 | Free-running timer value to be stamped |
| pin_in | input | 32 | Asynchronous input lines, index port*8+line |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
A line change is due to show in the flag and the capture bytes right after the third rising edge that follows it. The stored stamp is the timer value held in the cycle before that edge. A register write takes effect on the edge during which the strobe is high, and reads are combinational. The bench drives every input just after a falling edge and samples shortly after later falling edges, counting edges exactly for the capture-latency test. For the clear-versus-capture race it lines the write strobe up with that third edge; elsewhere it waits a margin of four edges.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
  localparam int DW         = 8;
  localparam int AW         = 3;
  localparam int PORT_FLD_W = 3;
  localparam int STAT_VALID_BIT = 0;

  localparam logic [AW-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [AW-1:0] ADDR_STAT     = 3'd1;
  localparam logic [AW-1:0] ADDR_CAP_BASE = 3'd4;

  // Address of capture byte k
  function automatic logic [AW-1:0] cap_byte_addr(input int k);
    return ADDR_CAP_BASE + AW'(k);
  endfunction
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);
  // Per line: [0] first sync stage, [1] synchronised level, [2] previous level
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], raw[g]};
    end
    assign rise[g] = sh[1] & ~sh[2];

    // R10: an edge is reported only for a level that was low one cycle earlier
    p_edge_from_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/evt_pin_mux.sv
module evt_pin_mux
  import evt_capture_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  localparam int PIN_W = $clog2(PINS),
  localparam int NPIN  = PORTS * PINS,
  localparam int IDX_W = $clog2(NPIN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPIN-1:0]       rise_vec,
  input  logic [PORT_FLD_W-1:0] port_sel,
  input  logic [PIN_W-1:0]      pin_sel,
  output logic                  sel_legal,
  output logic                  sel_rise
);
  function automatic logic legal_sel(input logic [PORT_FLD_W-1:0] p,
                                     input logic [PIN_W-1:0] n);
    return (int'(p) < PORTS) && (n != '0);
  endfunction

  function automatic logic [IDX_W-1:0] flat_index(input logic [PORT_FLD_W-1:0] p,
                                                  input logic [PIN_W-1:0] n);
    return IDX_W'(int'(p) * PINS + int'(n));
  endfunction

  logic [IDX_W-1:0] idx;
  assign idx       = flat_index(port_sel, pin_sel);
  assign sel_legal = legal_sel(port_sel, pin_sel);
  assign sel_rise  = sel_legal ? rise_vec[idx] : 1'b0;

  p_port_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(port_sel) >= PORTS) |-> !sel_rise);
  p_pin_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_sel == '0) |-> !sel_rise);
endmodule

// File: rtl/evt_store.sv
module evt_store #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer,
  input  logic          sel_rise,
  input  logic          clr_req,
  output logic [TW-1:0] cap_q,
  output logic          valid_q
);
  logic take_evt;
  assign take_evt = sel_rise & ~valid_q & ~clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take_evt) cap_q <= timer;
      if (clr_req)       valid_q <= 1'b0;
      else if (take_evt) valid_q <= 1'b1;
    end
  end

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rise && !valid_q && !clr_req) |=> (valid_q && cap_q == $past(timer)));
  p_set_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(sel_rise));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_req) |=> (valid_q && $stable(cap_q)));
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!valid_q && $stable(cap_q)));
endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_capture_pkg::*;
#(
  parameter int TW    = 32,
  parameter int PIN_W = 3,
  localparam int CTRL_W = PORT_FLD_W + PIN_W,
  localparam int NBYTES = TW / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  wr,
  input  logic [DW-1:0]         wdata,
  input  logic [TW-1:0]         cap_q,
  input  logic                  valid_q,
  output logic [PORT_FLD_W-1:0] port_sel,
  output logic [PIN_W-1:0]      pin_sel,
  output logic                  clr_req,
  output logic [DW-1:0]         rdata
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DW-1:CTRL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (wr && addr == ADDR_CTRL)  ctrl_q <= wdata[CTRL_W-1:0];
  end

  assign port_sel = ctrl_q[CTRL_W-1:PIN_W];
  assign pin_sel  = ctrl_q[PIN_W-1:0];
  assign clr_req  = wr && (addr == ADDR_STAT) && wdata[STAT_VALID_BIT];

  always_comb begin
    rdata = '0;
    if (addr == ADDR_CTRL) rdata[CTRL_W-1:0] = ctrl_q;
    if (addr == ADDR_STAT) rdata[STAT_VALID_BIT] = valid_q;
    for (int k = 0; k < NBYTES; k++) begin
      if (addr == cap_byte_addr(k)) rdata = cap_q[8*k +: 8];
    end
  end

  p_ctrl_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_CTRL) |-> (rdata[DW-1:CTRL_W] == '0));
  p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_CTRL) |=> ({port_sel, pin_sel} == $past(wdata[CTRL_W-1:0])));
  p_zero_write_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_STAT && !wdata[STAT_VALID_BIT]) |-> !clr_req);
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_capture_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int PINS  = 8,
  parameter int TW    = 32,
  localparam int PIN_W = $clog2(PINS),
  localparam int NPIN  = PORTS * PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   timer_val,
  input  logic [NPIN-1:0] pin_in,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata
);
  logic [NPIN-1:0]       rise_vec;
  logic [PORT_FLD_W-1:0] port_sel;
  logic [PIN_W-1:0]      pin_sel;
  logic                  sel_legal;
  logic                  sel_rise;
  logic                  clr_req;
  logic [TW-1:0]         cap_q;
  logic                  valid_q;

  evt_sync_edge #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .rise(rise_vec)
  );

  evt_pin_mux #(.PORTS(PORTS), .PINS(PINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .rise_vec(rise_vec),
    .port_sel(port_sel), .pin_sel(pin_sel),
    .sel_legal(sel_legal), .sel_rise(sel_rise)
  );

  evt_store #(.TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .timer(timer_val), .sel_rise(sel_rise),
    .clr_req(clr_req), .cap_q(cap_q), .valid_q(valid_q)
  );

  evt_regs #(.TW(TW), .PIN_W(PIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cap_q(cap_q), .valid_q(valid_q), .port_sel(port_sel), .pin_sel(pin_sel),
    .clr_req(clr_req), .rdata(bus_rdata)
  );

  // R4/R5: an inhibit code never lets the flag rise
  p_no_set_when_inhibited_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_legal && !valid_q) |=> !valid_q);
endmodule

// File: tb/evt_capture_tb.sv
`timescale 1ns/1ps
module evt_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timer_val = '0;
  logic [31:0] pin_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  evt_capture u_dut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .pin_in(pin_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic [5:0]  ctrl;
    logic [4:0]  line;
    logic [31:0] stamp;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{6'b000_001, 5'd1,  32'h1122_3344, 1'b1},  // R3 port 0 line 1
    '{6'b011_111, 5'd31, 32'hA5C3_0F96, 1'b1},  // R3 port 3 line 7
    '{6'b010_100, 5'd20, 32'h0000_00FF, 1'b1},  // R3 port 2 line 4
    '{6'b100_001, 5'd1,  32'hDEAD_BEEF, 1'b0},  // R4 port 4
    '{6'b111_011, 5'd27, 32'h0BAD_F00D, 1'b0},  // R4 port 7
    '{6'b001_000, 5'd8,  32'h5555_AAAA, 1'b0},  // R5 line 0
    '{6'b001_101, 5'd12, 32'h7777_1234, 1'b0},  // R10 other line
    '{6'b001_101, 5'd13, 32'hFFFF_0001, 1'b1}   // R3 port 1 line 5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic rd_cap(output logic [31:0] v);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      rd(3'(4 + k), b);
      v[8*k +: 8] = b;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %h expected %h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [31:0] v;
    logic [31:0] last_cap;
    logic [31:0] expc;
    vec_t        t;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(3'd0, d); check("R1 ctrl", {24'd0, d}, 32'd0);
    rd(3'd1, d); check("R1 status", {24'd0, d}, 32'd0);
    rd(3'd2, d); check("R1 unused", {24'd0, d}, 32'd0);
    rd_cap(v);   check("R1 capture", v, 32'd0);
    last_cap = 32'd0;

    // Table of vectors
    for (int i = 0; i < 8; i++) begin
      t = VECS[i];
      wr(3'd0, {2'b11, t.ctrl});
      wr(3'd1, 8'h01);
      rd(3'd0, d); check("R2 readback", {24'd0, d}, {26'd0, t.ctrl});
      timer_val = t.stamp;
      pin_in[t.line] = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd1, d);
      check(t.hit ? "R3 flag" : "R4/R5/R10 flag", {24'd0, d}, {31'd0, t.hit});
      expc = t.hit ? t.stamp : last_cap;
      rd_cap(v); check("R9 bytes", v, expc);
      last_cap = expc;
      pin_in = '0;
      repeat (4) @(negedge clk);
    end

    // R3 exact latency, stamp taken from the cycle before the third edge
    wr(3'd0, 8'b000_010);
    wr(3'd1, 8'h01);
    timer_val = 32'h0101_0101;
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(3'd1, d); check("R3 not yet", {24'd0, d}, 32'd0);
    timer_val = 32'h0202_0202;
    @(negedge clk);
    rd(3'd1, d); check("R3 third edge", {24'd0, d}, 32'd1);
    rd_cap(v);   check("R3 stamp", v, 32'h0202_0202);
    last_cap = 32'h0202_0202;

    // R6: second edge while flag set changes nothing
    pin_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    timer_val = 32'h9999_8888;
    pin_in[2] = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd1, d); check("R6 flag held", {24'd0, d}, 32'd1);
    rd_cap(v);   check("R6 value held", v, last_cap);

    // R7: writing 0 keeps the flag, writing 1 clears it
    wr(3'd1, 8'hFE);
    rd(3'd1, d); check("R7 zero write", {24'd0, d}, 32'd1);
    wr(3'd1, 8'h01);
    rd(3'd1, d); check("R7 clear", {24'd0, d}, 32'd0);

    // R8: clear on the same edge as a capture
    pin_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    timer_val = 32'h4444_3333;
    pin_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rd(3'd1, d); check("R8 flag", {24'd0, d}, 32'd0);
    rd_cap(v);   check("R8 value", v, last_cap);

    // R10: falling edge on selected line
    pin_in[2] = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd1, d); check("R10 falling", {24'd0, d}, 32'd0);

    // R10: selecting a line that is already high
    pin_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    wr(3'd0, 8'b000_101);
    repeat (5) @(negedge clk);
    rd(3'd1, d); check("R10 reselect", {24'd0, d}, 32'd0);
    rd_cap(v);   check("R10 value", v, last_cap);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule